// File: doc/BRIEF.md
# Timer-Event ADC Trigger Generator

This block turns events from an up/down PWM timer into a one-clock start pulse for an analog-to-digital converter. Three kinds of event can start a conversion: a compare match, qualified by the direction in which the timer was counting when the match happened; a peak event at the top of the count; and a valley event at the bottom. Peak and valley events reach this block after interrupt thinning has already been applied. Each source has its own enable bit in a small 4-bit configuration register.

The timer mode limits which enables take effect. Inside the block, an enable bit that is not legal in the current mode is forced to zero, whatever value software wrote. For bring-up and self-test, a built-in 16-bit triangular up/down counter with a compare value can stand in for the external timer. It has its own divide-by-N thinning on its peak and valley events. A select input chooses between the external events and the built-in counter.

Top module: `adc_trig_gen`

## Requirements
- R1: A cycle with `cfg_we_i` high loads `cfg_wdata_i` into the enable register, which takes effect from the next cycle. Bit 0 enables compare-while-up, bit 1 compare-while-down, bit 2 peak and bit 3 valley. After reset the register is 0 and `trig_o` is low.
- R2: Bits [1:0] form the compare direction field. 00 gives no compare trigger, 01 triggers only while counting up, 10 only while counting down, and 11 in either direction.
- R3: When bit 2 is effective, every peak event produces a trigger.
- R4: When bit 3 is effective, every valley event produces a trigger.
- R5: Bit 1 (compare-while-down) is effective only in mode codes 2 and 3. In every other mode it acts as 0.
- R6: Bit 0 (compare-while-up) is effective only in mode codes 1, 2, 3 and 4.
- R7: Bit 2 (peak) is effective only in mode codes 1, 2 and 4.
- R8: Bit 3 (valley) is effective only in mode codes 2 and 3. Mode codes 0, 5, 6 and 7 enable nothing. The codes mean: 1 PWM, 2 high-accuracy triangular PWM, 3 triangular-wave PWM, 4 PWM with dead time.
- R9: `trig_o` is high in the cycle after any effective source fires, and low otherwise. Several sources firing in the same cycle give exactly one one-cycle pulse.
- R10: While running, the built-in counter steps 0 up to `tc_top_i` and back down to 0. A top value of 0 is treated as 1. The peak event fires at the top and the valley event fires at 0 while counting down. A compare match at a turnaround point uses the direction before the reversal.
- R11: Built-in peak and valley events are each thinned by `thin_div_i`, so that every N-th event passes, starting with the N-th after reset. N of 0 or 1 passes every event. The thinning counters clear on reset.
- R12: With `src_int_i` high the external event inputs have no effect. With `src_int_i` low the built-in counter has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Enable register write strobe |
| cfg_wdata_i | input | 4 | Enable register write data |
| mode_i | input | 3 | Active timer mode code |
| src_int_i | input | 1 | 1: use built-in counter events, 0: use external events |
| ext_cmp_i | input | 1 | External compare-match event pulse |
| ext_dir_up_i | input | 1 | External count direction, 1 = up |
| ext_peak_i | input | 1 | External thinned peak event pulse |
| ext_valley_i | input | 1 | External thinned valley event pulse |
| tc_run_i | input | 1 | Built-in counter run enable |
| tc_top_i | input | CNT_W | Built-in counter top value |
| tc_cmp_i | input | CNT_W | Built-in counter compare value |
| thin_div_i | input | DIV_W | Built-in peak/valley thinning divisor |
| trig_o | output | 1 | Converter trigger pulse |

## Verification
A compare match can land in the same cycle as a peak or a valley when the compare value equals the top value or zero. In that cycle the compare trigger and the turnaround event both want the output, and the compare must be judged by the direction before the reversal. The bench provokes this by running the built-in counter with the compare value set to the top value or to zero. It also sweeps every combination of the four external event inputs with every mode and enable value. Each case is judged against an arithmetic model of the masking, the direction rule and the thinning, and the model expects a single pulse.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

  typedef enum logic [2:0] {
    TM_INTERVAL = 3'd0,
    TM_PWM      = 3'd1,
    TM_HA_TRI   = 3'd2,
    TM_TRI      = 3'd3,
    TM_PWM_DT   = 3'd4,
    TM_RSV5     = 3'd5,
    TM_RSV6     = 3'd6,
    TM_RSV7     = 3'd7
  } tmr_mode_e;

  // packed: vl is bit 3, pk bit 2, cmp_dn bit 1, cmp_up bit 0
  typedef struct packed {
    logic vl;
    logic pk;
    logic cmp_dn;
    logic cmp_up;
  } trig_en_t;

endpackage

// File: rtl/trig_en_mask.sv
module trig_en_mask
  import adc_trig_pkg::*;
(
  input  trig_en_t   raw_i,
  input  logic [2:0] mode_i,
  output trig_en_t   eff_o
);

  logic ok_up, ok_dn, ok_pk, ok_vl;

  always_comb begin
    ok_up = 1'b0;
    ok_dn = 1'b0;
    ok_pk = 1'b0;
    ok_vl = 1'b0;
    case (tmr_mode_e'(mode_i))
      TM_PWM: begin
        ok_up = 1'b1;
        ok_pk = 1'b1;
      end
      TM_HA_TRI: begin
        ok_up = 1'b1;
        ok_dn = 1'b1;
        ok_pk = 1'b1;
        ok_vl = 1'b1;
      end
      TM_TRI: begin
        ok_up = 1'b1;
        ok_dn = 1'b1;
        ok_vl = 1'b1;
      end
      TM_PWM_DT: begin
        ok_up = 1'b1;
        ok_pk = 1'b1;
      end
      default: begin
        ok_up = 1'b0;
      end
    endcase
  end

  always_comb begin
    eff_o.cmp_up = raw_i.cmp_up & ok_up;
    eff_o.cmp_dn = raw_i.cmp_dn & ok_dn;
    eff_o.pk     = raw_i.pk     & ok_pk;
    eff_o.vl     = raw_i.vl     & ok_vl;
  end

endmodule

// File: rtl/tri_test_cnt.sv
module tri_test_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             up_o,
  output logic             cmp_evt_o,
  output logic             peak_evt_o,
  output logic             valley_evt_o
);

  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] cnt_q, cnt_d, top_eff;
  logic             up_q, up_d;
  logic             at_top, at_bot;

  always_comb begin
    top_eff = (top_i == ZERO) ? ONE : top_i;
    at_top  = up_q && (cnt_q >= top_eff);
    at_bot  = !up_q && (cnt_q == ZERO);
  end

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (run_i) begin
      if (at_top) begin
        up_d  = 1'b0;
        cnt_d = cnt_q - ONE;
      end else if (at_bot) begin
        up_d  = 1'b1;
        cnt_d = ONE;
      end else if (up_q) begin
        cnt_d = cnt_q + ONE;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= ZERO;
      up_q  <= 1'b1;
    end else if (run_i) begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  always_comb begin
    cnt_o        = cnt_q;
    up_o         = up_q;
    cmp_evt_o    = run_i && (cnt_q == cmp_i);
    peak_evt_o   = run_i && at_top;
    valley_evt_o = run_i && at_bot;
  end

endmodule

// File: rtl/evt_thin.sv
module evt_thin #(
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             evt_i,
  output logic             evt_o
);

  localparam logic [DIV_W-1:0] ONE  = {{(DIV_W-1){1'b0}}, 1'b1};
  localparam logic [DIV_W-1:0] ZERO = '0;

  logic [DIV_W-1:0] cnt_q, cnt_d, last;
  logic             pass;

  always_comb begin
    last  = ((div_i == ZERO) ? ONE : div_i) - ONE;
    pass  = evt_i && (cnt_q >= last);
    cnt_d = pass ? ZERO : (cnt_q + ONE);
    evt_o = pass;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= ZERO;
    end else if (evt_i) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/adc_trig_gen.sv
module adc_trig_gen
  import adc_trig_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [3:0]       cfg_wdata_i,
  input  logic [2:0]       mode_i,
  input  logic             src_int_i,
  input  logic             ext_cmp_i,
  input  logic             ext_dir_up_i,
  input  logic             ext_peak_i,
  input  logic             ext_valley_i,
  input  logic             tc_run_i,
  input  logic [CNT_W-1:0] tc_top_i,
  input  logic [CNT_W-1:0] tc_cmp_i,
  input  logic [DIV_W-1:0] thin_div_i,
  output logic             trig_o
);

  localparam int N_THIN = 2;

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_sync;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  // enable register
  trig_en_t en_q, en_d, en_eff;
  always_comb en_d = cfg_we_i ? trig_en_t'(cfg_wdata_i) : en_q;

  always_ff @(posedge clk_i or negedge rst_sync) begin
    if (!rst_sync) en_q <= '0;
    else           en_q <= en_d;
  end

  trig_en_mask u_mask (
    .raw_i  (en_q),
    .mode_i (mode_i),
    .eff_o  (en_eff)
  );

  // built-in test counter
  logic [CNT_W-1:0] tc_cnt;
  logic             tc_up, tc_cmp, tc_peak, tc_valley;

  tri_test_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync),
    .run_i        (tc_run_i),
    .top_i        (tc_top_i),
    .cmp_i        (tc_cmp_i),
    .cnt_o        (tc_cnt),
    .up_o         (tc_up),
    .cmp_evt_o    (tc_cmp),
    .peak_evt_o   (tc_peak),
    .valley_evt_o (tc_valley)
  );

  // thinning of built-in peak [0] and valley [1]
  logic [N_THIN-1:0] thin_in, thin_out;
  always_comb thin_in = {tc_valley, tc_peak};

  for (genvar gi = 0; gi < N_THIN; gi++) begin : g_thin
    evt_thin #(.DIV_W(DIV_W)) u_thin (
      .clk_i  (clk_i),
      .rst_ni (rst_sync),
      .div_i  (thin_div_i),
      .evt_i  (thin_in[gi]),
      .evt_o  (thin_out[gi])
    );
  end

  // source selection
  logic sel_cmp, sel_dir, sel_peak, sel_valley;
  always_comb begin
    if (src_int_i) begin
      sel_cmp    = tc_cmp;
      sel_dir    = tc_up;
      sel_peak   = thin_out[0];
      sel_valley = thin_out[1];
    end else begin
      sel_cmp    = ext_cmp_i;
      sel_dir    = ext_dir_up_i;
      sel_peak   = ext_peak_i;
      sel_valley = ext_valley_i;
    end
  end

  // trigger combine and register
  logic cmp_hit, trig_d, trig_q;
  always_comb begin
    cmp_hit = sel_cmp && (sel_dir ? en_eff.cmp_up : en_eff.cmp_dn);
    trig_d  = cmp_hit || (sel_peak && en_eff.pk) || (sel_valley && en_eff.vl);
  end

  always_ff @(posedge clk_i or negedge rst_sync) begin
    if (!rst_sync) trig_q <= 1'b0;
    else           trig_q <= trig_d;
  end

  assign trig_o = trig_q;

endmodule

// File: rtl/adc_trig_gen_chk.sv
module adc_trig_gen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic [2:0]       mode_i,
  input logic             sel_cmp,
  input logic             sel_dir,
  input logic             sel_peak,
  input logic             sel_valley,
  input logic             trig_o,
  input logic [CNT_W-1:0] tc_cnt,
  input logic             tc_up,
  input logic [CNT_W-1:0] tc_top_i
);

  // R9: a pulse needs a source event in the cycle before
  assert_trig_has_source_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    trig_o |-> $past(sel_cmp || sel_peak || sel_valley));

  // R6 (with R5, R7, R8): modes 0, 5, 6, 7 never trigger
  assert_mode_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    trig_o |-> ($past(mode_i) >= 3'd1 && $past(mode_i) <= 3'd4));

  assert_down_cmp_legal_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (trig_o && $past(sel_cmp && !sel_dir && !sel_peak && !sel_valley))
      |-> ($past(mode_i) == 3'd2 || $past(mode_i) == 3'd3));

  assert_valley_legal_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (trig_o && $past(sel_valley && !sel_cmp && !sel_peak))
      |-> ($past(mode_i) == 3'd2 || $past(mode_i) == 3'd3));

  assert_turn_top_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(tc_up) |-> ($past(tc_cnt) >= $past(tc_top_i)));

  assert_turn_bottom_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(tc_up) |-> ($past(tc_cnt) == '0));

endmodule

bind adc_trig_gen adc_trig_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_n      (rst_sync),
  .mode_i     (mode_i),
  .sel_cmp    (sel_cmp),
  .sel_dir    (sel_dir),
  .sel_peak   (sel_peak),
  .sel_valley (sel_valley),
  .trig_o     (trig_o),
  .tc_cnt     (tc_cnt),
  .tc_up      (tc_up),
  .tc_top_i   (tc_top_i)
);

// File: tb/adc_trig_gen_bench.sv
module adc_trig_gen_bench;

  localparam int CNT_W = 16;
  localparam int DIV_W = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_we;
  logic [3:0]       cfg_wdata;
  logic [2:0]       mode;
  logic             src_int;
  logic             e_cmp, e_dir, e_pk, e_vl;
  logic             run;
  logic [CNT_W-1:0] top, cmpv;
  logic [DIV_W-1:0] thin;
  logic             trig;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  adc_trig_gen #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_adc_trig_gen (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .mode_i(mode), .src_int_i(src_int), .ext_cmp_i(e_cmp), .ext_dir_up_i(e_dir),
    .ext_peak_i(e_pk), .ext_valley_i(e_vl), .tc_run_i(run), .tc_top_i(top),
    .tc_cmp_i(cmpv), .thin_div_i(thin), .trig_o(trig)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL [%s] t=%0t trig act=%0b exp=%0b", req, $time, act, exp);
    end
  endtask

  function automatic logic [3:0] mask(input int m, input logic [3:0] r);
    logic [3:0] k;
    k[0] = (m >= 1 && m <= 4);          // R6
    k[1] = (m == 2 || m == 3);          // R5
    k[2] = (m == 1 || m == 2 || m == 4); // R7
    k[3] = (m == 2 || m == 3);          // R8
    return r & k;
  endfunction

  function automatic logic expect_trig(input logic [3:0] en, input logic c,
                                       input logic d, input logic p, input logic v);
    return (c && (d ? en[0] : en[1])) || (p && en[2]) || (v && en[3]);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; mode = '0; src_int = 1'b0;
    e_cmp = 1'b0; e_dir = 1'b0; e_pk = 1'b0; e_vl = 1'b0; run = 1'b0;
    top = '0; cmpv = '0; thin = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic write_en(input logic [3:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  // lockstep model of the built-in counter path
  task automatic run_int(input string req, input int t, input int c, input int m,
                         input logic [3:0] r, input int n, input int cycles);
    int cnt, up, pk_c, vl_c, te, ne;
    logic ev_c, ev_p, ev_v, pp, pv, ex;
    logic [3:0] en;
    do_reset();
    mode = 3'(m);
    write_en(r);
    src_int = 1'b1; top = CNT_W'(t); cmpv = CNT_W'(c); thin = DIV_W'(n);
    cnt = 0; up = 1; pk_c = 0; vl_c = 0;
    te = (t == 0) ? 1 : t;
    ne = (n == 0) ? 1 : n;
    en = mask(m, r);
    run = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      ev_c = (cnt == c);
      ev_p = (up == 1) && (cnt >= te);
      ev_v = (up == 0) && (cnt == 0);
      pp = ev_p && (pk_c >= ne - 1);
      pv = ev_v && (vl_c >= ne - 1);
      ex = expect_trig(en, ev_c, (up == 1), pp, pv);
      if (ev_p) pk_c = pp ? 0 : pk_c + 1;
      if (ev_v) vl_c = pv ? 0 : vl_c + 1;
      if (ev_p) begin up = 0; cnt = cnt - 1; end
      else if (ev_v) begin up = 1; cnt = 1; end
      else if (up == 1) cnt = cnt + 1;
      else cnt = cnt - 1;
      @(negedge clk);
      chk(req, trig, ex);
    end
    run = 1'b0;
  endtask

  initial begin : watchdog
    #(4 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL [watchdog] run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    do_reset();

    // R1: reset state, enable register cleared
    chk("R1 reset output", trig, 1'b0);
    mode = 3'd2; e_cmp = 1'b1; e_dir = 1'b1; e_pk = 1'b1; e_vl = 1'b1;
    @(negedge clk);
    chk("R1 reset enables zero", trig, 1'b0);
    e_dir = 1'b0;
    @(negedge clk);
    chk("R1 reset enables zero", trig, 1'b0);
    e_cmp = 1'b0; e_pk = 1'b0; e_vl = 1'b0;

    // R2..R9 exhaustive sweep of external events, modes and enable values
    for (int m = 0; m < 8; m++) begin
      for (int r = 0; r < 16; r++) begin
        e_cmp = 1'b0; e_dir = 1'b0; e_pk = 1'b0; e_vl = 1'b0;
        mode = 3'(m);
        write_en(4'(r));
        for (int v = 0; v < 16; v++) begin
          {e_vl, e_pk, e_dir, e_cmp} = 4'(v);
          @(negedge clk);
          chk("R1 R2 R3 R4 R5 R6 R7 R8 R9 sweep", trig,
              expect_trig(mask(m, 4'(r)), e_cmp, e_dir, e_pk, e_vl));
        end
      end
    end
    e_cmp = 1'b0; e_dir = 1'b0; e_pk = 1'b0; e_vl = 1'b0;
    @(negedge clk);
    chk("R9 pulse ends", trig, 1'b0);

    // R10 R11 R9: built-in counter runs
    run_int("R10 R2 R3 R4 triangle",            5, 3, 2, 4'hF, 1, 40);
    run_int("R10 compare at top counts up",     4, 4, 1, 4'h1, 1, 40);
    run_int("R10 compare at zero counts down",  4, 0, 3, 4'h2, 1, 40);
    run_int("R11 thinning by three",            6, 2, 2, 4'hC, 3, 90);
    run_int("R10 R11 top zero div zero",        0, 9, 4, 4'h4, 0, 20);
    run_int("R9 coincident compare and peak",   3, 3, 2, 4'h5, 2, 40);

    // R12: external ignored when internal selected (counter stopped)
    do_reset();
    mode = 3'd2;
    write_en(4'hF);
    src_int = 1'b1; run = 1'b0; top = 16'd3; cmpv = 16'd7;
    e_cmp = 1'b1; e_pk = 1'b1; e_vl = 1'b1;
    for (int i = 0; i < 6; i++) begin
      e_dir = 1'(i);
      @(negedge clk);
      chk("R12 external ignored", trig, 1'b0);
    end
    // R12: internal ignored when external selected
    e_cmp = 1'b0; e_pk = 1'b0; e_vl = 1'b0; e_dir = 1'b0;
    src_int = 1'b0; run = 1'b1; cmpv = 16'd1; thin = 4'd1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R12 counter ignored", trig, 1'b0);
    end
    run = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule